// File: doc/BRIEF.md
# Bidirectional storage bus transceiver

This block connects two 18-bit data ports, A and B, through two separate storage stages, one for each direction. Each stage has three behaviours, chosen at run time. It can pass its input through (pass mode), keep its current word (hold mode), or take a new word when an external strobe rises (load mode). A level enable input selects pass mode. When that enable is low, a rising edge on the direction's strobe line loads a new word.

Everything runs on one system clock. The two strobe lines come from outside that clock domain, so each goes through a synchronizer before its rising edges are detected. The block has no tri-state pins. Each output port instead gives a data word and a drive flag, and the data word reads as zero while the port is not driving. The A-to-B output enable is active high. The B-to-A output enable is active low.

Top module: `bidir_store_xcvr`

## Requirements
- R1: Reset (`rst_n` low) clears both stored words to zero. After reset, enabling an output with no further loads shows an all-zero word with the drive flag high.
- R2: While `ab_le` is high, the A-to-B word takes `a_in` on every system clock edge. `b_out` shows that value one clock after it is applied. This holds for any bit pattern in all 18 bits.
- R3: While `ab_le` is low and `ab_strobe` stays at one level, high or low, the stored word does not change and changes on `a_in` have no effect. A falling strobe edge loads nothing.
- R4: While `ab_le` is low, a rising edge on `ab_strobe` loads `a_in`. The strobe passes through two synchronizer flops. The new word appears after the third rising system clock edge that follows the strobe going high, and it has not appeared after the second.
- R5: While `ab_oe` is 0, `b_drive` is 0 and `b_out` is all zeros. Loads can still take place during that time.
- R6: Turning the output off and back on leaves the stored word unchanged. When `ab_oe` returns to 1, `b_out` shows whatever the stage holds at that moment, including a word loaded while the output was off.
- R7: If `ab_le` falls while `ab_strobe` is already high, the stage keeps the last value it passed through. It ignores the new `a_in`.
- R8: The B-to-A direction follows the same rules, using `ba_le`, `ba_strobe` and `b_in`. Its output enable `ba_oe_n` is active low: 0 drives `a_out` and sets `a_drive`; 1 sets `a_drive` to 0 and `a_out` to zero.
- R9: The two directions are independent. Activity in the B-to-A direction does not change the A-to-B stored word.
- R10: Whenever only one direction's output enable is asserted, at most one of `a_drive` and `b_drive` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| a_in | input | 18 | Data arriving on port A |
| b_in | input | 18 | Data arriving on port B |
| ab_le | input | 1 | A-to-B pass-mode enable |
| ab_strobe | input | 1 | A-to-B load strobe, asynchronous, rising edge |
| ab_oe | input | 1 | A-to-B output enable, active high |
| ba_le | input | 1 | B-to-A pass-mode enable |
| ba_strobe | input | 1 | B-to-A load strobe, asynchronous, rising edge |
| ba_oe_n | input | 1 | B-to-A output enable, active low |
| b_out | output | 18 | Word presented on port B |
| b_drive | output | 1 | Port B drive flag |
| a_out | output | 18 | Word presented on port A |
| a_drive | output | 1 | Port A drive flag |

## Verification
The hardest case to reach from the ports is R7: the enable falls while the synchronized strobe is already high, so the stage leaves pass mode with no load edge to follow. The stimulus raises the strobe while the stage is still in pass mode and waits long enough for the synchronizer to settle. It then drops the enable and changes `a_in` in the same cycle, and checks that the output keeps the word from before. The load latency in R4 is checked on both sides of the edge: the old word one cycle early, the new word exactly on time.

// File: rtl/xcvr_pkg.sv
// Shared types for the bidirectional storage transceiver.
package xcvr_pkg;

    // Action a storage stage takes in a given system clock cycle.
    typedef enum logic [1:0] {
        ACT_HOLD = 2'd0,
        ACT_PASS = 2'd1,
        ACT_LOAD = 2'd2
    } store_act_e;

    // Pass mode wins over a detected strobe edge; otherwise an edge loads.
    function automatic store_act_e pick_act(input logic le, input logic rise_hit);
        if (le)
            return ACT_PASS;
        if (rise_hit)
            return ACT_LOAD;
        return ACT_HOLD;
    endfunction

endpackage

// File: rtl/strobe_sync.sv
// Brings an asynchronous strobe into the system clock domain and flags
// its rising edges as one-cycle pulses.
// Assumes STAGES >= 2 and that the strobe stays high or low for longer
// than a system clock period, so no edge is lost.
module strobe_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe_i,
    output logic rise_o
);
    logic [STAGES-1:0] chain;
    logic              last;

    // Shift the strobe through the synchronizer and keep the previous output.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain <= '0;
            last  <= 1'b0;
        end else begin
            chain <= {chain[STAGES-2:0], strobe_i};
            last  <= chain[STAGES-1];
        end
    end

    // Rising edge: the synchronized level is high now and was low before.
    always_comb rise_o = chain[STAGES-1] & ~last;
endmodule

// File: rtl/store_stage.sv
// One direction's storage word. It can pass its input each cycle, hold
// its word, or load the input when a rising strobe edge arrives.
// Assumes rise_i is a single-cycle pulse in the clk domain.
module store_stage
    import xcvr_pkg::*;
#(
    parameter int WIDTH = 18
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             le_i,
    input  logic             rise_i,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    store_act_e act;

    // Work out this cycle's action from the enable and the edge pulse.
    always_comb act = pick_act(le_i, rise_i);

    // Update the stored word as the chosen action says.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_o <= '0;
        end else begin
            case (act)
                ACT_PASS: q_o <= d_i;
                ACT_LOAD: q_o <= d_i;
                default:  q_o <= q_o;
            endcase
        end
    end
endmodule

// File: rtl/drive_gate.sv
// Replaces a tri-state output: produces a data word and a drive flag.
// The word reads as zero while the port is not driving.
// ACTIVE_HIGH sets the polarity of the enable input.
module drive_gate #(
    parameter int WIDTH       = 18,
    parameter bit ACTIVE_HIGH = 1'b1
) (
    input  logic             oe_i,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] d_o,
    output logic             drv_o
);
    logic on;

    generate
        if (ACTIVE_HIGH) begin : g_hi
            // Enable is active high.
            always_comb on = oe_i;
        end else begin : g_lo
            // Enable is active low.
            always_comb on = ~oe_i;
        end
    endgenerate

    // Pass the word through only while the port is driving.
    always_comb begin
        drv_o = on;
        d_o   = on ? d_i : '0;
    end
endmodule

// File: rtl/xcvr_path.sv
// One complete direction: strobe synchronizer, storage stage and output gate.
// Also brings out the edge pulse and the stored word so the checker can see them.
module xcvr_path #(
    parameter int WIDTH          = 18,
    parameter int SYNC_STAGES    = 2,
    parameter bit OE_ACTIVE_HIGH = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] src_i,
    input  logic             le_i,
    input  logic             strobe_i,
    input  logic             oe_i,
    output logic [WIDTH-1:0] dst_o,
    output logic             drv_o,
    output logic             rise_o,
    output logic [WIDTH-1:0] word_o
);
    strobe_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .strobe_i (strobe_i),
        .rise_o   (rise_o)
    );

    store_stage #(.WIDTH(WIDTH)) u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .le_i   (le_i),
        .rise_i (rise_o),
        .d_i    (src_i),
        .q_o    (word_o)
    );

    drive_gate #(.WIDTH(WIDTH), .ACTIVE_HIGH(OE_ACTIVE_HIGH)) u_gate (
        .oe_i  (oe_i),
        .d_i   (word_o),
        .d_o   (dst_o),
        .drv_o (drv_o)
    );
endmodule

// File: rtl/bidir_store_xcvr.sv
// Two-port transceiver with an independent storage stage in each direction.
// A to B uses an active-high output enable; B to A uses an active-low one.
// Assumes both strobes are asynchronous and everything else is synchronous to clk.
module bidir_store_xcvr #(
    parameter int WIDTH       = 18,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] a_in,
    input  logic [WIDTH-1:0] b_in,
    input  logic             ab_le,
    input  logic             ab_strobe,
    input  logic             ab_oe,
    input  logic             ba_le,
    input  logic             ba_strobe,
    input  logic             ba_oe_n,
    output logic [WIDTH-1:0] b_out,
    output logic             b_drive,
    output logic [WIDTH-1:0] a_out,
    output logic             a_drive
);
    logic             ab_edge;
    logic             ba_edge;
    logic [WIDTH-1:0] ab_word;
    logic [WIDTH-1:0] ba_word;

    xcvr_path #(.WIDTH(WIDTH), .SYNC_STAGES(SYNC_STAGES), .OE_ACTIVE_HIGH(1'b1)) u_ab (
        .clk      (clk),
        .rst_n    (rst_n),
        .src_i    (a_in),
        .le_i     (ab_le),
        .strobe_i (ab_strobe),
        .oe_i     (ab_oe),
        .dst_o    (b_out),
        .drv_o    (b_drive),
        .rise_o   (ab_edge),
        .word_o   (ab_word)
    );

    xcvr_path #(.WIDTH(WIDTH), .SYNC_STAGES(SYNC_STAGES), .OE_ACTIVE_HIGH(1'b0)) u_ba (
        .clk      (clk),
        .rst_n    (rst_n),
        .src_i    (b_in),
        .le_i     (ba_le),
        .strobe_i (ba_strobe),
        .oe_i     (ba_oe_n),
        .dst_o    (a_out),
        .drv_o    (a_drive),
        .rise_o   (ba_edge),
        .word_o   (ba_word)
    );
endmodule

// File: rtl/bidir_store_xcvr_chk.sv
// Property checker attached to the transceiver top. It watches the ports
// together with each direction's edge pulse and stored word.
module bidir_store_xcvr_chk #(
    parameter int WIDTH = 18
) (
    input logic             clk,
    input logic             rst_n,
    input logic [WIDTH-1:0] a_in,
    input logic [WIDTH-1:0] b_in,
    input logic             ab_le,
    input logic             ba_le,
    input logic             ab_oe,
    input logic             ba_oe_n,
    input logic [WIDTH-1:0] a_out,
    input logic [WIDTH-1:0] b_out,
    input logic             a_drive,
    input logic             b_drive,
    input logic             ab_edge,
    input logic             ba_edge,
    input logic [WIDTH-1:0] ab_word,
    input logic [WIDTH-1:0] ba_word
);
    AST_AB_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        ab_le |=> ab_word == $past(a_in)); // R2
    AST_AB_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!ab_le && !ab_edge) |=> $stable(ab_word)); // R3
    AST_AB_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (!ab_le && ab_edge) |=> ab_word == $past(a_in)); // R4
    AST_EDGE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        ab_edge |=> !ab_edge); // R4
    AST_AB_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !ab_oe |-> (!b_drive && b_out == '0)); // R5
    AST_AB_SHOW: assert property (@(posedge clk) disable iff (!rst_n)
        ab_oe |-> (b_drive && b_out == ab_word)); // R6
    AST_BA_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        ba_oe_n |-> (!a_drive && a_out == '0)); // R8
    AST_BA_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        ba_le |=> ba_word == $past(b_in)); // R8
    AST_BA_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (!ba_le && ba_edge) |=> ba_word == $past(b_in)); // R8
endmodule

bind bidir_store_xcvr bidir_store_xcvr_chk #(.WIDTH(WIDTH)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .a_in    (a_in),
    .b_in    (b_in),
    .ab_le   (ab_le),
    .ba_le   (ba_le),
    .ab_oe   (ab_oe),
    .ba_oe_n (ba_oe_n),
    .a_out   (a_out),
    .b_out   (b_out),
    .a_drive (a_drive),
    .b_drive (b_drive),
    .ab_edge (ab_edge),
    .ba_edge (ba_edge),
    .ab_word (ab_word),
    .ba_word (ba_word)
);

// File: tb/bidir_store_xcvr_test.sv
// Scoreboard bench: the driver queues expected port values, and the monitor
// pops them and compares at the falling clock edge.
module bidir_store_xcvr_test;
    localparam int W = 18;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] a_in = '0, b_in = '0;
    logic         ab_le = 1'b0, ab_strobe = 1'b0, ab_oe = 1'b0;
    logic         ba_le = 1'b0, ba_strobe = 1'b0, ba_oe_n = 1'b1;
    logic [W-1:0] a_out, b_out;
    logic         a_drive, b_drive;

    int checks = 0;
    int bad = 0;
    int conflicts = 0;

    typedef struct {
        string        req;
        bit           side_a;
        logic [W-1:0] d;
        logic         dr;
    } item_t;
    item_t sb[$];

    always #5 clk = ~clk;

    bidir_store_xcvr uut (
        .clk(clk), .rst_n(rst_n), .a_in(a_in), .b_in(b_in),
        .ab_le(ab_le), .ab_strobe(ab_strobe), .ab_oe(ab_oe),
        .ba_le(ba_le), .ba_strobe(ba_strobe), .ba_oe_n(ba_oe_n),
        .b_out(b_out), .b_drive(b_drive), .a_out(a_out), .a_drive(a_drive)
    );

    // Monitor: compare each queued item, and count drive conflicts (R10).
    always @(negedge clk) begin
        while (sb.size() > 0) begin
            item_t it;
            logic [W-1:0] gd;
            logic gr;
            it = sb.pop_front();
            gd = it.side_a ? a_out : b_out;
            gr = it.side_a ? a_drive : b_drive;
            checks++;
            if (gd !== it.d || gr !== it.dr) begin
                bad++;
                $display("FAIL %s port %s: data=%h drive=%b expected data=%h drive=%b",
                         it.req, it.side_a ? "A" : "B", gd, gr, it.d, it.dr);
            end
        end
        if (rst_n && a_drive && b_drive) conflicts++;
    end

    task automatic tick(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic settle();
        @(negedge clk);
        #1;
    endtask

    task automatic exp_b(string req, logic [W-1:0] d, logic dr);
        sb.push_back('{req, 1'b0, d, dr});
    endtask

    task automatic exp_a(string req, logic [W-1:0] d, logic dr);
        sb.push_back('{req, 1'b1, d, dr});
    endtask

    initial begin
        #500_000;
        bad++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

    initial begin
        logic [W-1:0] pats[5];
        pats = '{18'h3FFFF, 18'h2AAAA, 18'h15555, 18'h00001, 18'h20000};

        tick(3);
        rst_n = 1'b1;
        tick(1);
        exp_b("R1", '0, 1'b0); exp_a("R1", '0, 1'b0); settle();
        ab_oe = 1'b1; tick(1);
        exp_b("R1", '0, 1'b1); settle();

        // R2 pass mode across several patterns
        ab_le = 1'b1;
        foreach (pats[i]) begin
            a_in = pats[i]; tick(1);
            exp_b("R2", pats[i], 1'b1); settle();
        end

        // R3 hold with the strobe low
        a_in = 18'h0F0F0; tick(1);
        ab_le = 1'b0; a_in = 18'h3C3C3; tick(4);
        exp_b("R3", 18'h0F0F0, 1'b1); settle();
        a_in = 18'h12345; tick(2);
        exp_b("R3", 18'h0F0F0, 1'b1); settle();

        // R4 load on strobe rise, with exact latency
        a_in = 18'h2D2D2; ab_strobe = 1'b1; tick(2);
        exp_b("R4", 18'h0F0F0, 1'b1); settle();
        tick(1);
        exp_b("R4", 18'h2D2D2, 1'b1); settle();
        a_in = 18'h11111; tick(4);
        exp_b("R3", 18'h2D2D2, 1'b1); settle();
        ab_strobe = 1'b0; tick(4);
        exp_b("R3", 18'h2D2D2, 1'b1); settle();

        // R7 enable falls while the strobe is already high
        ab_le = 1'b1; a_in = 18'h0ABCD; ab_strobe = 1'b1; tick(4);
        exp_b("R2", 18'h0ABCD, 1'b1); settle();
        ab_le = 1'b0; a_in = 18'h3F00F; tick(3);
        exp_b("R7", 18'h0ABCD, 1'b1); settle();
        ab_strobe = 1'b0; tick(3);

        // R5 output off, and a load while it is off
        ab_oe = 1'b0; tick(1);
        exp_b("R5", '0, 1'b0); settle();
        a_in = 18'h1E1E1; ab_strobe = 1'b1; tick(4);
        ab_strobe = 1'b0;
        exp_b("R5", '0, 1'b0); settle();
        ab_oe = 1'b1; tick(1);
        exp_b("R6", 18'h1E1E1, 1'b1); settle();
        ab_oe = 1'b0; tick(2); ab_oe = 1'b1; tick(1);
        exp_b("R6", 18'h1E1E1, 1'b1); settle();

        // R8 B to A direction with the active-low enable
        ab_oe = 1'b0; ba_oe_n = 1'b0; tick(1);
        exp_a("R8", '0, 1'b1); exp_b("R5", '0, 1'b0); settle();
        ba_le = 1'b1; b_in = 18'h35A5A; tick(1);
        exp_a("R8", 18'h35A5A, 1'b1); settle();
        ba_le = 1'b0; b_in = 18'h00FF0; tick(3);
        exp_a("R8", 18'h35A5A, 1'b1); settle();
        ba_strobe = 1'b1; tick(2);
        exp_a("R8", 18'h35A5A, 1'b1); settle();
        tick(1);
        exp_a("R8", 18'h00FF0, 1'b1); settle();
        ba_strobe = 1'b0; ba_oe_n = 1'b1; tick(1);
        exp_a("R8", '0, 1'b0); settle();

        // R9 the A-to-B word is untouched by B-to-A activity
        ab_oe = 1'b1; tick(1);
        exp_b("R9", 18'h1E1E1, 1'b1); settle();

        // R10 no cycle in which both ports drove
        checks++;
        if (conflicts != 0) begin
            bad++;
            $display("FAIL R10: conflict cycles=%0d expected 0", conflicts);
        end

        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end
endmodule